// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous Static RAM

This block connects a synchronous request port inside a chip to an external asynchronous static RAM that holds 1M words of 16 bits. A requester offers one access at a time. Each access has a read/write flag, a 20-bit word address, 16 bits of write data and a two-bit lane mask. Bit 0 of the mask selects the low byte (bits 7:0) and bit 1 selects the high byte (bits 15:8). The controller turns each access into a sequence of memory pin states. The memory is selected through a pair of enables of opposite polarity: the active-low one is driven low and the active-high one is driven high. One active-low enable per byte lane gates the data. The write and output strobes are held long enough to meet the memory's 45 ns cycle time.

The shared data bus is modelled as three signals: an incoming value, an outgoing value and a drive enable. The controller drives the bus only while write data must reach the memory. It keeps the drive enable low whenever the output strobe is active, and also in the cycle that follows it. The memory's data pins float when it is deselected, when its output strobe is inactive, when both lanes are disabled, or while a write strobe is active. The controller's pin sequencing respects each of these conditions.

A read returns its data with a one-cycle valid pulse. Any lane that was not requested reads back as zero. When the controller is idle it leaves the memory deselected, so the memory stays in standby.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is high, and in every idle cycle after it, the active-low select is 1, the active-high select is 0, the write strobe is 1, the output strobe is 1, both lane enables are 1 and the bus drive enable is 0.
- R2: The memory is selected only while an access is in progress. Selected means the active-low select is 0 and the active-high select is 1.
- R3: The strobe length in cycles is the access time divided by the clock period, rounded up. This gives 5 cycles for 45 ns at a 10 ns clock. No write or output strobe is ever shorter than this.
- R4: A write drives the write strobe low for the strobe length. During that time each lane enable is the inverse of its mask bit (bit 0 for the low byte, bit 1 for the high byte), and the bus carries the write data. Only the enabled bytes change in the memory.
- R5: After a write strobe there is one recovery cycle. In that cycle the write strobe is 1 while the selects, the address and the bus drive stay unchanged. The memory is deselected only after that cycle.
- R6: A read drives the output strobe low for the strobe length. During that time the write strobe is 1 and each lane enable is the inverse of its mask bit.
- R7: The response valid is high for one cycle, in the cycle that follows the last strobe cycle of a read. The returned word holds the memory data in the requested lanes and zero in the other lanes.
- R8: The bus drive enable is 0 in every cycle in which the output strobe is 0, and in the cycle after such a cycle.
- R9: A request whose mask is 00 leaves every memory pin at its idle level. For a read, the response valid is high in the next cycle and the data is 0. A write with mask 00 gives no response. Request ready stays high.
- R10: The address stays unchanged throughout each selected period.
- R11: Request ready is high only when idle. A request is taken in a cycle where both request valid and request ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 16 | Read data, unrequested lanes zero |
| mem_addr | output | 20 | Memory address |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel | output | 1 | Active-high memory select |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_lane_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| mem_dq_in | input | 16 | Data arriving from the memory bus |
| mem_dq_out | output | 16 | Data driven onto the memory bus |
| mem_dq_oe | output | 1 | Bus drive enable |

## Verification
Two events can fall in the same cycle: the response pulse that ends a read, and the taking of a new request. The read's last strobe cycle hands over to an idle cycle. That idle cycle both raises response valid and allows a write to be taken, so the write's strobe starts in the very next cycle. The bench provokes this by offering a write straight after a read and by chaining reads with different masks. It judges the pins every cycle against a behavioural model. The model requires that the bus is not driven in the turnaround cycle and that the response data is correct while the new access begins.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STROBE  = 2'd1,
        ST_RECOVER = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  mask;
    } mem_req_t;

    typedef struct packed {
        logic             sel_n;
        logic             sel;
        logic             we_n;
        logic             oe_n;
        logic [LANES-1:0] lane_n;
        logic             bus_drive;
    } mem_pins_t;

    // Cycles needed to cover the access time, rounded up, at least one.
    function automatic int strobe_cycles(input int period_ps, input int access_ps);
        int w;
        w = (access_ps + period_ps - 1) / period_ps;
        if (w < 1) w = 1;
        return w;
    endfunction

    // Zero every lane whose mask bit is clear.
    function automatic logic [DATA_W-1:0] lane_filter(input logic [DATA_W-1:0] d,
                                                      input logic [LANES-1:0]  m);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int i = 0; i < LANES; i++) begin
            if (m[i]) r[i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int WAIT_CYCLES = 5,
    localparam int CNT_W = $clog2(WAIT_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + CNT_W'(1);
    end

    assign last = run && (cnt_q == CNT_W'(WAIT_CYCLES - 1));
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_lane_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  mem_req_t   req_in,
    input  logic       strobe_last,
    output seq_state_e state,
    output mem_req_t   req_q,
    output logic       req_ready,
    output logic       capture,
    output logic       zero_rsp
);
    seq_state_e state_q, state_d;
    mem_req_t   hold_q;
    logic       take;

    assign req_ready = (state_q == ST_IDLE);
    assign take      = req_valid && req_ready;
    assign zero_rsp  = take && (req_in.mask == '0) && !req_in.write;
    assign capture   = (state_q == ST_STROBE) && strobe_last && !hold_q.write;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take && (req_in.mask != '0)) state_d = ST_STROBE;
            end
            ST_STROBE: begin
                if (strobe_last) state_d = hold_q.write ? ST_RECOVER : ST_IDLE;
            end
            ST_RECOVER: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take && (req_in.mask != '0)) hold_q <= req_in;
        end
    end

    assign state = state_q;
    assign req_q = hold_q;
endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
    import sram_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  mem_req_t          req_q,
    input  logic              capture,
    input  logic              zero_rsp,
    input  logic [DATA_W-1:0] dq_in,
    output mem_pins_t         pins,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic active;
    logic wr_strobe;
    logic rd_strobe;
    logic valid_q;
    logic [DATA_W-1:0] data_q;

    assign active    = (state != ST_IDLE);
    assign wr_strobe = (state == ST_STROBE) && req_q.write;
    assign rd_strobe = (state == ST_STROBE) && !req_q.write;

    assign pins.sel_n     = !active;
    assign pins.sel       = active;
    assign pins.we_n      = !wr_strobe;
    assign pins.oe_n      = !rd_strobe;
    assign pins.bus_drive = active && req_q.write;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign pins.lane_n[g] = !(active && req_q.mask[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= capture || zero_rsp;
            if (capture)       data_q <= lane_filter(dq_in, req_q.mask);
            else if (zero_rsp) data_q <= '0;
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_rdata = data_q;
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int T_ACCESS_PS   = 45000,
    localparam int WAIT_CYCLES  = strobe_cycles(CLK_PERIOD_PS, T_ACCESS_PS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_lane_n,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);
    mem_req_t   req_in;
    mem_req_t   req_q;
    seq_state_e state;
    mem_pins_t  pins;
    logic       strobe_last;
    logic       capture;
    logic       zero_rsp;

    assign req_in = '{write: req_write, addr: req_addr, wdata: req_wdata, mask: req_mask};

    sram_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_STROBE),
        .last (strobe_last)
    );

    sram_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_in      (req_in),
        .strobe_last (strobe_last),
        .state       (state),
        .req_q       (req_q),
        .req_ready   (req_ready),
        .capture     (capture),
        .zero_rsp    (zero_rsp)
    );

    sram_pin_drive u_pins (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .req_q     (req_q),
        .capture   (capture),
        .zero_rsp  (zero_rsp),
        .dq_in     (mem_dq_in),
        .pins      (pins),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_addr   = req_q.addr;
    assign mem_sel_n  = pins.sel_n;
    assign mem_sel    = pins.sel;
    assign mem_we_n   = pins.we_n;
    assign mem_oe_n   = pins.oe_n;
    assign mem_lane_n = pins.lane_n;
    assign mem_dq_out = req_q.wdata;
    assign mem_dq_oe  = pins.bus_drive;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int WAIT_CYC = 5,
    parameter int ADDR_W_C = 20,
    parameter int LANES_C  = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                req_ready,
    input logic                mem_sel_n,
    input logic                mem_sel,
    input logic                mem_we_n,
    input logic                mem_oe_n,
    input logic [LANES_C-1:0]  mem_lane_n,
    input logic                mem_dq_oe,
    input logic [ADDR_W_C-1:0] mem_addr
);
    logic strobe;
    int   run_len;

    assign strobe = !mem_we_n || !mem_oe_n;

    always_ff @(posedge clk) begin
        if (rst)         run_len <= 0;
        else if (strobe) run_len <= run_len + 1;
        else             run_len <= 0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && (&mem_lane_n) && !mem_dq_oe)); // R1
    AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (!mem_sel_n && mem_sel)); // R2
    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (!strobe && run_len != 0) |-> (run_len >= WAIT_CYC)); // R3
    AST_WE_BEFORE_DESELECT: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_sel_n) |-> $past(mem_we_n)); // R5
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n); // R6
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe); // R8
    AST_NO_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        $past(!mem_oe_n) |-> !mem_dq_oe); // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!mem_sel_n && !$past(mem_sel_n)) |-> $stable(mem_addr)); // R10
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .WAIT_CYC (WAIT_CYCLES),
    .ADDR_W_C (sram_lane_pkg::ADDR_W),
    .LANES_C  (sram_lane_pkg::LANES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_lane_n (mem_lane_n),
    .mem_dq_oe  (mem_dq_oe),
    .mem_addr   (mem_addr)
);

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb;
    localparam int CLK_PS   = 10000;
    localparam int ACC_PS   = 45000;
    localparam int EXP_WAIT = (ACC_PS + CLK_PS - 1) / CLK_PS;
    localparam real HALF_NS = CLK_PS / 2000.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr  = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask  = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [19:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_dq_in = 16'hA5A5;
    logic [15:0] mem_dq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string scen = "R1";

    sram_lane_ctrl #(.CLK_PERIOD_PS(CLK_PS), .T_ACCESS_PS(ACC_PS)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lane_n(mem_lane_n),
        .mem_dq_in(mem_dq_in), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
    );

    always #(HALF_NS) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s [%s] actual=%h expected=%h t=%0t", tag, what, scen, act, exp, $time);
        end
    endtask

    // Memory device model: bytes land on the memory while the write strobe is low.
    logic [15:0] dev_mem [int];
    always @(negedge clk) begin
        logic [15:0] w;
        w = dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : 16'h0000;
        if (!mem_sel_n && mem_sel && !mem_we_n) begin
            if (!mem_lane_n[0]) w[7:0]  = mem_dq_out[7:0];
            if (!mem_lane_n[1]) w[15:8] = mem_dq_out[15:8];
            dev_mem[int'(mem_addr)] = w;
        end
        mem_dq_in = 16'hA5A5;
        if (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n) begin
            if (!mem_lane_n[0]) mem_dq_in[7:0]  = w[7:0];
            if (!mem_lane_n[1]) mem_dq_in[15:8] = w[15:8];
        end
    end

    // Behavioural reference: phase 0 idle, 1 strobe, 2 recovery.
    logic [15:0] ref_mem [int];
    int          m_phase = 0;
    int          m_cnt   = 0;
    logic        m_wr    = 1'b0;
    logic [19:0] m_addr  = '0;
    logic [15:0] m_wdata = '0;
    logic [1:0]  m_mask  = '0;
    logic        m_rsp   = 1'b0;
    logic [15:0] m_rdata = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_rsp = 0; m_rdata = 0;
        end else begin
            m_rsp = 0;
            case (m_phase)
                0: if (req_valid) begin
                    if (req_mask == 2'b00) begin
                        if (!req_write) begin m_rsp = 1; m_rdata = 16'h0000; end
                    end else begin
                        m_wr = req_write; m_addr = req_addr; m_wdata = req_wdata;
                        m_mask = req_mask; m_phase = 1; m_cnt = 0;
                    end
                end
                1: if (m_cnt == EXP_WAIT - 1) begin
                    if (m_wr) begin
                        logic [15:0] v;
                        v = ref_mem.exists(int'(m_addr)) ? ref_mem[int'(m_addr)] : 16'h0000;
                        if (m_mask[0]) v[7:0]  = m_wdata[7:0];
                        if (m_mask[1]) v[15:8] = m_wdata[15:8];
                        ref_mem[int'(m_addr)] = v;
                        m_phase = 2;
                    end else begin
                        logic [15:0] v;
                        v = ref_mem.exists(int'(m_addr)) ? ref_mem[int'(m_addr)] : 16'h0000;
                        m_rdata = {m_mask[1] ? v[15:8] : 8'h00, m_mask[0] ? v[7:0] : 8'h00};
                        m_rsp = 1; m_phase = 0;
                    end
                end else m_cnt++;
                default: m_phase = 0;
            endcase
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            bit act, rd;
            act = (m_phase != 0);
            rd  = (m_phase == 1) && !m_wr;
            check(req_ready == !act, "R11", "req_ready", req_ready, !act);
            check(mem_sel_n == !act && mem_sel == act, "R2", "selects", {mem_sel_n, mem_sel}, {!act, act});
            check(mem_we_n == !((m_phase == 1) && m_wr), "R4", "we_n", mem_we_n, !((m_phase == 1) && m_wr));
            check(mem_oe_n == !rd, "R6", "oe_n", mem_oe_n, !rd);
            check(mem_lane_n == (act ? ~m_mask : 2'b11), "R1", "lane_n", mem_lane_n, act ? ~m_mask : 2'b11);
            check(mem_dq_oe == (act && m_wr), "R8", "dq_oe", mem_dq_oe, act && m_wr);
            check(rsp_valid == m_rsp, "R7", "rsp_valid", rsp_valid, m_rsp);
            if (m_rsp) check(rsp_rdata == m_rdata, "R7", "rsp_rdata", rsp_rdata, m_rdata);
            if (act) check(mem_addr == m_addr, "R10", "mem_addr", mem_addr, m_addr);
            if (act && m_wr) check(mem_dq_out == m_wdata, "R4", "dq_out", mem_dq_out, m_wdata);
            if (m_phase == 2) check(mem_we_n == 1'b1 && !mem_sel_n && mem_dq_oe, "R5", "recovery", {mem_we_n, mem_sel_n, mem_dq_oe}, 3'b101);
        end
    end

    task automatic do_req(input logic w, input logic [19:0] a, input logic [15:0] d, input logic [1:0] m);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(HALF_NS * 2 * 50000);
        check(0, "R11", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        check(EXP_WAIT >= 5, "R3", "strobe cycles at 100 MHz", EXP_WAIT, 5);
        repeat (3) @(negedge clk);
        check(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && mem_lane_n == 2'b11 && !mem_dq_oe,
              "R1", "pins in reset", {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe}, 7'b1011110);
        rst = 1'b0;
        scen = "R4";
        do_req(1, 20'h00012, 16'h1234, 2'b11);
        do_req(1, 20'hFFFFF, 16'h5566, 2'b11);
        scen = "R7";
        do_req(0, 20'h00012, 16'h0, 2'b11);
        scen = "R8";
        do_req(1, 20'h00012, 16'hABCD, 2'b10);
        do_req(0, 20'h00012, 16'h0, 2'b11);
        do_req(0, 20'h00012, 16'h0, 2'b01);
        do_req(0, 20'h00012, 16'h0, 2'b10);
        do_req(1, 20'hFFFFF, 16'h99EE, 2'b01);
        do_req(0, 20'hFFFFF, 16'h0, 2'b11);
        scen = "R9";
        do_req(1, 20'h00012, 16'hFFFF, 2'b00);
        do_req(0, 20'h00012, 16'h0, 2'b00);
        do_req(0, 20'h00012, 16'h0, 2'b11);
        repeat (12) @(negedge clk);
        scen = "R4";
        check(dev_mem[int'(20'h00012)] == 16'hAB34, "R4", "lane write low", dev_mem[int'(20'h00012)], 16'hAB34);
        check(dev_mem[int'(20'hFFFFF)] == 16'h55EE, "R4", "lane write high", dev_mem[int'(20'hFFFFF)], 16'h55EE);
        finish_run();
    end
endmodule